// File: doc/BRIEF.md
# Stack Register Rename Map

This block turns the eight stack-relative register names of a stack-organised floating-point unit, st(0) through st(7), into physical register slot numbers. It holds a 3-bit top-of-stack pointer, a table that maps each absolute stack position to a physical slot, and one occupancy bit per physical slot. A push moves the top down by one and a pop moves it up by one. An exchange of st(0) with st(i) swaps two table entries. Register data is never moved, so an exchange costs no datapath cycle.

Each clock the block can take one stack adjustment (push or pop), one exchange, and one operand lookup. It reports where st(0) and the looked-up st(i) live after all of that cycle's renames. This lets the arithmetic operation and the exchange that follows it both be renamed in the same cycle without a stall. It also reports overflow when a push lands on an occupied slot, and underflow when an operation touches an empty one. All outputs are combinational, and the map state updates on the clock edge.

Top module: `fpstk_rename_map`

## Requirements
- R1: After reset, the table holds the identity mapping (position k maps to slot k), the top pointer is 0 and every slot is empty. With no operation, st(i) resolves to slot i.
- R2: `stk_op_i` is encoded as 00 none, 01 push, 10 pop, 11 none. A push decrements the top pointer modulo 8 in the same cycle, so the new st(0) is the slot mapped at the old top minus one, and that slot becomes occupied.
- R3: A pop increments the top pointer modulo 8 and marks the old st(0) slot empty.
- R4: An exchange with index i swaps the table entries at positions top and top+i (modulo 8). Afterwards st(0) and st(i) resolve to each other's former slots, and the occupancy of every slot is unchanged.
- R5: `top_slot_o` and `rd_slot_o` reflect the exchange and stack adjustment requested in the same cycle.
- R6: When a push and an exchange are requested together, the push is applied first and the exchange uses the new top.
- R7: When a pop and an exchange are requested together, the pop is applied first and the exchange uses the new top.
- R8: `overflow_o` is 1 exactly when a push targets a slot that is already occupied.
- R9: `underflow_o` is 1 when a pop finds st(0) empty, when an enabled lookup resolves to a slot that is empty after this cycle's stack adjustment, or when an exchange involves an empty slot.
- R10: Any sequence of renames and exchanges keeps the table a permutation of the eight slots, and no operation inserts a wait cycle: every request is applied in the cycle it appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stk_op_i | input | 2 | Stack adjustment: 00 none, 01 push, 10 pop, 11 none |
| xch_en_i | input | 1 | Exchange st(0) with st(xch_idx_i) this cycle |
| xch_idx_i | input | 3 | Stack-relative index of the exchange partner |
| rd_en_i | input | 1 | Operand lookup is active (affects underflow) |
| rd_idx_i | input | 3 | Stack-relative index of the looked-up operand |
| top_slot_o | output | 3 | Physical slot of st(0) after this cycle's renames |
| rd_slot_o | output | 3 | Physical slot of st(rd_idx_i) after this cycle's renames |
| overflow_o | output | 1 | Push onto an occupied slot |
| underflow_o | output | 1 | Pop, lookup or exchange touching an empty slot |

## Verification
The hardest states to reach are those where the table is far from the identity and the top pointer has wrapped. Only there can an ordering error between a push or pop and a same-cycle exchange be told apart from correct behaviour. The stimulus first runs directed pushes to fill all eight slots and force an overflow, then pops to force an underflow. It then issues long random runs that mix push or pop with exchanges of every index, which scramble the table. A bench reference model predicts every output in every cycle.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;
    localparam int STK_DEPTH = 8;
    localparam int SLOT_W    = $clog2(STK_DEPTH);

    typedef logic [SLOT_W-1:0] slot_t;

    typedef enum logic [1:0] {
        STK_NONE = 2'b00,
        STK_PUSH = 2'b01,
        STK_POP  = 2'b10,
        STK_IDLE = 2'b11
    } stk_op_e;

    typedef struct packed {
        logic  push;
        logic  pop;
        slot_t new_top;
    } stk_step_t;

    // Stack positions wrap naturally because the depth is a power of two.
    function automatic slot_t pos_add(slot_t base, slot_t ofs);
        return slot_t'(base + ofs);
    endfunction
endpackage

// File: rtl/fpstk_top_ptr.sv
module fpstk_top_ptr
    import fpstk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  stk_op_e   op,
    output slot_t     top_q,
    output stk_step_t step
);
    always_comb begin
        step.push    = (op == STK_PUSH);
        step.pop     = (op == STK_POP);
        step.new_top = top_q;
        if (step.push)
            step.new_top = slot_t'(top_q - slot_t'(1));
        else if (step.pop)
            step.new_top = slot_t'(top_q + slot_t'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) top_q <= '0;
        else     top_q <= step.new_top;
    end
endmodule

// File: rtl/fpstk_name_table.sv
module fpstk_name_table
    import fpstk_pkg::*;
#(
    parameter int DEPTH = STK_DEPTH,
    parameter int SW    = SLOT_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    swap_en,
    input  logic [SW-1:0]           swap_a,
    input  logic [SW-1:0]           swap_b,
    input  logic [SW-1:0]           rd0_pos,
    input  logic [SW-1:0]           rd1_pos,
    output logic [SW-1:0]           rd0_slot,
    output logic [SW-1:0]           rd1_slot,
    output logic [DEPTH-1:0][SW-1:0] tbl_q
);
    function automatic logic [SW-1:0] swapped_view(logic [SW-1:0] pos);
        if (swap_en && pos == swap_a) return tbl_q[swap_b];
        if (swap_en && pos == swap_b) return tbl_q[swap_a];
        return tbl_q[pos];
    endfunction

    assign rd0_slot = swapped_view(rd0_pos);
    assign rd1_slot = swapped_view(rd1_pos);

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                tbl_q[g] <= SW'(g);
            else if (swap_en && swap_a == SW'(g))
                tbl_q[g] <= tbl_q[swap_b];
            else if (swap_en && swap_b == SW'(g))
                tbl_q[g] <= tbl_q[swap_a];
        end
    end
endmodule

// File: rtl/fpstk_occupancy.sv
module fpstk_occupancy
    import fpstk_pkg::*;
#(
    parameter int DEPTH = STK_DEPTH,
    parameter int SW    = SLOT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [SW-1:0]    set_slot,
    input  logic             clr_en,
    input  logic [SW-1:0]    clr_slot,
    output logic [DEPTH-1:0] valid_q,
    output logic [DEPTH-1:0] valid_nx
);
    always_comb begin
        valid_nx = valid_q;
        if (set_en) valid_nx[set_slot] = 1'b1;
        if (clr_en) valid_nx[clr_slot] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) valid_q <= '0;
        else     valid_q <= valid_nx;
    end
endmodule

// File: rtl/fpstk_rename_map.sv
module fpstk_rename_map
    import fpstk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] stk_op_i,
    input  logic       xch_en_i,
    input  logic [2:0] xch_idx_i,
    input  logic       rd_en_i,
    input  logic [2:0] rd_idx_i,
    output logic [2:0] top_slot_o,
    output logic [2:0] rd_slot_o,
    output logic       overflow_o,
    output logic       underflow_o
);
    stk_op_e                       op;
    stk_step_t                     step;
    slot_t                         top_q;
    slot_t                         xch_pos;
    slot_t                         rd_pos;
    slot_t                         push_slot;
    slot_t                         pop_slot;
    logic [STK_DEPTH-1:0][SLOT_W-1:0] tbl_q;
    logic [STK_DEPTH-1:0]          valid_q;
    logic [STK_DEPTH-1:0]          valid_nx;

    assign op = stk_op_e'(stk_op_i);

    fpstk_top_ptr u_ptr (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .top_q (top_q),
        .step  (step)
    );

    // Exchange and lookups are resolved against the already adjusted top.
    assign xch_pos   = pos_add(step.new_top, slot_t'(xch_idx_i));
    assign rd_pos    = pos_add(step.new_top, slot_t'(rd_idx_i));
    assign push_slot = tbl_q[step.new_top];
    assign pop_slot  = tbl_q[top_q];

    fpstk_name_table #(.DEPTH(STK_DEPTH), .SW(SLOT_W)) u_tbl (
        .clk      (clk),
        .rst      (rst),
        .swap_en  (xch_en_i),
        .swap_a   (step.new_top),
        .swap_b   (xch_pos),
        .rd0_pos  (step.new_top),
        .rd1_pos  (rd_pos),
        .rd0_slot (top_slot_o),
        .rd1_slot (rd_slot_o),
        .tbl_q    (tbl_q)
    );

    fpstk_occupancy #(.DEPTH(STK_DEPTH), .SW(SLOT_W)) u_occ (
        .clk      (clk),
        .rst      (rst),
        .set_en   (step.push),
        .set_slot (push_slot),
        .clr_en   (step.pop),
        .clr_slot (pop_slot),
        .valid_q  (valid_q),
        .valid_nx (valid_nx)
    );

    assign overflow_o  = step.push && valid_q[push_slot];
    assign underflow_o = (step.pop && !valid_q[pop_slot])
                       || (rd_en_i && !valid_nx[rd_slot_o])
                       || (xch_en_i && (!valid_nx[tbl_q[step.new_top]]
                                        || !valid_nx[tbl_q[xch_pos]]));
endmodule

// File: rtl/fpstk_rename_map_chk.sv
module fpstk_rename_map_chk
    import fpstk_pkg::*;
(
    input logic                         clk,
    input logic                         rst,
    input logic [1:0]                   stk_op,
    input logic                         xch_en,
    input slot_t                        top_q,
    input logic [STK_DEPTH-1:0][SLOT_W-1:0] tbl_q,
    input logic [STK_DEPTH-1:0]         valid_q,
    input logic                         overflow
);
    logic [STK_DEPTH-1:0] seen;
    always_comb begin
        seen = '0;
        for (int k = 0; k < STK_DEPTH; k++) seen[tbl_q[k]] = 1'b1;
    end

    p_table_perm_r10: assert property (@(posedge clk) disable iff (rst)
        &seen);

    p_push_dec_r2: assert property (@(posedge clk) disable iff (rst)
        (stk_op == 2'b01) |=> (slot_t'(top_q + slot_t'(1)) == $past(top_q)));

    p_pop_inc_r3: assert property (@(posedge clk) disable iff (rst)
        (stk_op == 2'b10) |=> (top_q == slot_t'($past(top_q) + slot_t'(1))));

    p_idle_top_r1: assert property (@(posedge clk) disable iff (rst)
        (stk_op == 2'b00 || stk_op == 2'b11) |=> $stable(top_q));

    p_xch_keeps_valid_r4: assert property (@(posedge clk) disable iff (rst)
        (xch_en && (stk_op == 2'b00 || stk_op == 2'b11)) |=> $stable(valid_q));

    p_overflow_push_r8: assert property (@(posedge clk) disable iff (rst)
        overflow |-> (stk_op == 2'b01));
endmodule

bind fpstk_rename_map fpstk_rename_map_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .stk_op   (stk_op_i),
    .xch_en   (xch_en_i),
    .top_q    (top_q),
    .tbl_q    (tbl_q),
    .valid_q  (valid_q),
    .overflow (overflow_o)
);

// File: tb/fpstk_rename_map_tb_top.sv
module fpstk_rename_map_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] stk_op_i = 2'b00;
    logic       xch_en_i = 1'b0;
    logic [2:0] xch_idx_i = 3'd0;
    logic       rd_en_i = 1'b0;
    logic [2:0] rd_idx_i = 3'd0;
    logic [2:0] top_slot_o, rd_slot_o;
    logic       overflow_o, underflow_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int m_map[8];
    int m_top;
    bit m_valid[8];

    always #(CLK_PERIOD/2) clk = ~clk;

    fpstk_rename_map dut_i (
        .clk(clk), .rst(rst), .stk_op_i(stk_op_i), .xch_en_i(xch_en_i),
        .xch_idx_i(xch_idx_i), .rd_en_i(rd_en_i), .rd_idx_i(rd_idx_i),
        .top_slot_o(top_slot_o), .rd_slot_o(rd_slot_o),
        .overflow_o(overflow_o), .underflow_o(underflow_o)
    );

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 8; k++) begin
            m_map[k] = k;
            m_valid[k] = 0;
        end
        m_top = 0;
    endtask

    // Drive one cycle of requests, check combinational outputs, advance the model.
    task automatic step(int op, bit xen, int xidx, bit ren, int ridx, string tag);
        int nt, push_s, pop_s, a, b, e_top, e_rd, tmp;
        bit push, pop, e_ovf, e_unf;
        int m2[8];
        bit veff[8];
        @(negedge clk);
        stk_op_i = 2'(op); xch_en_i = xen; xch_idx_i = 3'(xidx);
        rd_en_i = ren; rd_idx_i = 3'(ridx);
        push = (op == 1); pop = (op == 2);
        nt = push ? (m_top + 7) % 8 : pop ? (m_top + 1) % 8 : m_top;
        push_s = m_map[nt]; pop_s = m_map[m_top];
        veff = m_valid;
        if (push) veff[push_s] = 1;
        if (pop) veff[pop_s] = 0;
        m2 = m_map;
        a = nt; b = (nt + xidx) % 8;
        if (xen) begin tmp = m2[a]; m2[a] = m2[b]; m2[b] = tmp; end
        e_top = m2[nt];
        e_rd = m2[(nt + ridx) % 8];
        e_ovf = push && m_valid[push_s];
        e_unf = (pop && !m_valid[pop_s]) || (ren && !veff[e_rd])
              || (xen && (!veff[m2[a]] || !veff[m2[b]]));
        #1;
        chk(tag, "top_slot", int'(top_slot_o), e_top);
        chk(tag, "rd_slot", int'(rd_slot_o), e_rd);
        chk(tag, "overflow", int'(overflow_o), int'(e_ovf));
        chk(tag, "underflow", int'(underflow_o), int'(e_unf));
        @(posedge clk);
        m_top = nt; m_map = m2; m_valid = veff;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5a17;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: identity map, empty slots
        step(0, 0, 0, 1, 3, "R1");
        @(negedge clk); rd_idx_i = 3'd5; rd_en_i = 1'b0; #1;
        chk("R1", "idle rd_slot", int'(rd_slot_o), 5);
        chk("R1", "idle underflow", int'(underflow_o), 0);

        // R2: push from reset lands on slot 7
        @(negedge clk); stk_op_i = 2'b01; rd_en_i = 1'b0; xch_en_i = 1'b0; #1;
        chk("R2", "first push top_slot", int'(top_slot_o), 7);
        chk("R2", "first push overflow", int'(overflow_o), 0);
        @(posedge clk); m_top = 7; m_valid[7] = 1;
        // R2: code 11 acts as no operation
        step(3, 0, 0, 1, 0, "R2");
        // fill the stack
        for (int k = 0; k < 7; k++) step(1, 0, 0, 1, 0, "R2");
        // R8: ninth push overflows
        step(1, 0, 0, 0, 0, "R8");
        // R4/R5: exchange in a scrambled full stack
        step(0, 1, 3, 1, 3, "R4");
        step(0, 1, 5, 1, 0, "R5");
        // R6: push with exchange
        step(1, 1, 2, 1, 2, "R6");
        // R3 / R9: drain and underflow
        for (int k = 0; k < 8; k++) step(2, 0, 0, 0, 0, "R3");
        step(2, 0, 0, 0, 0, "R9");
        step(0, 0, 0, 1, 4, "R9");
        step(0, 1, 1, 0, 0, "R9");
        // R7: pop with exchange after a partial refill
        for (int k = 0; k < 4; k++) step(1, 0, 0, 0, 0, "R2");
        step(2, 1, 2, 1, 1, "R7");

        // R10: random mix of renames
        for (int n = 0; n < 2000; n++) begin
            int op;
            op = int'($urandom_range(0, 3));
            step(op, bit'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
                 bit'($urandom_range(0, 1)), int'($urandom_range(0, 7)), "R10");
        end

        // R1 again: reset returns the identity map
        @(negedge clk); rst = 1'b1; stk_op_i = 2'b00; xch_en_i = 1'b0; rd_en_i = 1'b0;
        @(posedge clk); model_reset();
        @(negedge clk); rst = 1'b0;
        step(0, 0, 0, 1, 6, "R1");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule